// File: doc/BRIEF.md
# ADC Result Register Bank

This block holds the most recent conversion result of each of eight analog input channels. The conversion side presents a channel number, a 10-bit result and a one-cycle write pulse. The result is stored in the register that belongs to that channel, left-aligned in a 16-bit word whose six low bits are always zero.

The CPU side is an 8-bit read path. It also offers a word mode that returns both bytes in one access. Each register occupies two byte addresses, with the upper byte at the even address. Reading the upper byte returns it straight from the live register. The same read copies the live lower byte into one holding byte that all channels share.

A later lower-byte read returns that holding byte and not the live register. This keeps a byte-by-byte read coherent while conversions keep landing. Requests flagged as writes are ignored, because the registers are read-only. Read data appears one clock after the request.

Top module: `adc_result_bank`

## Requirements
- R1: A conversion write with channel number N updates only result register N. No other register changes.
- R2: A register holding 10-bit result V reads as the 16-bit value {V, 6'b000000}, so bits 5:0 are always zero.
- R3: A byte read at even address 2N returns bits 15:8 of live register N on rd_data[7:0], with rd_data[15:8] zero.
- R4: A byte read at odd address 2N+1 returns the holding byte on rd_data[7:0], with rd_data[15:8] zero. It does not return the live register.
- R5: A read of an upper byte loads the holding byte with bits 7:0 of the same register as sampled in that cycle. A lower-byte read leaves the holding byte unchanged.
- R6: A word read (cpu_word=1, address bit 0 ignored) returns both bytes of register N from one sample on rd_data[15:0]. It also loads the holding byte like an upper-byte read.
- R7: After reset every result register reads 0x0000 and the holding byte reads 0x00.
- R8: A request with cpu_we=1 produces no read response and changes neither the result registers nor the holding byte.
- R9: When a conversion write and a read target the same register in one cycle, the read and any holding-byte capture see the old value. The new value is visible from the next cycle onward.
- R10: A single holding byte serves all eight channels, so a lower-byte read returns the capture made by the most recent upper-byte or word read of any channel.
- R11: rd_valid is high exactly in the cycle after a read request (cpu_req=1, cpu_we=0). rd_data holds its value while no read occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| conv_we | input | 1 | Conversion result write pulse |
| conv_ch | input | 3 | Channel number of the conversion result |
| conv_res | input | 10 | Conversion result |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | Access is a write (ignored) |
| cpu_word | input | 1 | Word access instead of byte access |
| cpu_addr | input | 4 | Byte address: bits 3:1 select the register, bit 0 selects the lower byte |
| rd_data | output | 16 | Read data, valid when rd_valid is high |
| rd_valid | output | 1 | Read response strobe, one clock after the request |

## Verification
The bench builds the bank with its default parameters: eight channels, 10-bit results, an 8-bit bus and 16-bit registers. Every channel is therefore reachable through the 4-bit byte address, and the six zero padding bits are visible on both word and lower-byte reads. With this size, random traffic often places a conversion and a read on the same register in one cycle. Upper-byte reads of two different channels also often come before a single lower-byte read, so the collision rule and the shared holding byte are exercised heavily alongside the directed cases.

// File: rtl/adc_bank_pkg.sv
package adc_bank_pkg;
  // Decoded CPU access kind for one cycle
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_HI   = 2'd1,
    ACC_LO   = 2'd2,
    ACC_WORD = 2'd3
  } acc_e;
endpackage

// File: rtl/adc_bank_rst_sync.sv
module adc_bank_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/adc_bank_store.sv
module adc_bank_store #(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [CH_W-1:0]              wr_ch,
  input  logic [RES_W-1:0]             wr_res,
  output logic [NUM_CH-1:0][RES_W-1:0] res_q
);
  // Only the significant result bits are stored; padding is added on read.
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic             ch_en;
    logic [RES_W-1:0] ch_d;

    always_comb begin
      ch_en = wr_en && (wr_ch == CH_W'(g));
      ch_d  = ch_en ? wr_res : res_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_q[g] <= '0;
      else        res_q[g] <= ch_d;
    end
  end
endmodule

// File: rtl/adc_bank_port.sv
module adc_bank_port
  import adc_bank_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  parameter int BUS_W  = 8,
  parameter int CH_W   = $clog2(NUM_CH),
  localparam int REG_W = 2 * BUS_W,
  localparam int PAD_W = REG_W - RES_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  acc_e                         acc,
  input  logic [CH_W-1:0]              sel,
  input  logic [NUM_CH-1:0][RES_W-1:0] res_i,
  output logic [REG_W-1:0]             rd_data,
  output logic                         rd_valid
);
  logic [REG_W-1:0] live;
  logic [BUS_W-1:0] tmp_q, tmp_d;
  logic             tmp_en;
  logic [REG_W-1:0] data_q, data_d;
  logic             data_en;
  logic             valid_q, valid_d;

  // Live register value, left-aligned with zero padding
  always_comb begin
    live = {res_i[sel], {PAD_W{1'b0}}};
  end

  always_comb begin
    tmp_en  = (acc == ACC_HI) || (acc == ACC_WORD);
    tmp_d   = live[BUS_W-1:0];
    data_en = (acc != ACC_NONE);
    valid_d = data_en;
    unique case (acc)
      ACC_HI:   data_d = {{BUS_W{1'b0}}, live[REG_W-1:BUS_W]};
      ACC_LO:   data_d = {{BUS_W{1'b0}}, tmp_q};
      ACC_WORD: data_d = live;
      default:  data_d = data_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmp_q <= '0;
    else if (tmp_en) tmp_q <= tmp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  assign rd_data  = data_q;
  assign rd_valid = valid_q;
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_bank_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int RES_W   = 10,
  parameter int BUS_W   = 8,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + 1,
  localparam int REG_W  = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_we,
  input  logic [CH_W-1:0]   conv_ch,
  input  logic [RES_W-1:0]  conv_res,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              cpu_word,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              rd_valid
);
  logic                         rst_q_n;
  logic [NUM_CH-1:0][RES_W-1:0] res_q;
  acc_e                         acc;
  logic [CH_W-1:0]              sel;

  adc_bank_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  // Access decode: writes are dropped here, so they reach no state.
  always_comb begin
    sel = cpu_addr[ADDR_W-1:1];
    if (!cpu_req || cpu_we) acc = ACC_NONE;
    else if (cpu_word)      acc = ACC_WORD;
    else if (cpu_addr[0])   acc = ACC_LO;
    else                    acc = ACC_HI;
  end

  adc_bank_store #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .wr_en  (conv_we),
    .wr_ch  (conv_ch),
    .wr_res (conv_res),
    .res_q  (res_q)
  );

  adc_bank_port #(.NUM_CH(NUM_CH), .RES_W(RES_W), .BUS_W(BUS_W), .CH_W(CH_W)) u_port (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .acc      (acc),
    .sel      (sel),
    .res_i    (res_q),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );
endmodule

// File: rtl/adc_bank_chk.sv
module adc_bank_chk #(
  parameter int BUS_W = 8,
  localparam int REG_W = 2 * BUS_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_req,
  input logic             cpu_we,
  input logic             cpu_word,
  input logic [REG_W-1:0] rd_data,
  input logic             rd_valid
);
  logic rd_now;
  assign rd_now = cpu_req && !cpu_we;

  p_valid_after_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_now |=> rd_valid);

  p_no_stray_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_now |=> !rd_valid);

  p_hold_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_now |=> $stable(rd_data));

  p_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we) |=> (!rd_valid && $stable(rd_data)));

  p_byte_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_now && !cpu_word) |=> (rd_data[REG_W-1:BUS_W] == '0));

  p_word_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_now && cpu_word) |=> (rd_data[5:0] == 6'd0));
endmodule

bind adc_result_bank adc_bank_chk #(.BUS_W(BUS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .cpu_req  (cpu_req),
  .cpu_we   (cpu_we),
  .cpu_word (cpu_word),
  .rd_data  (rd_data),
  .rd_valid (rd_valid)
);

// File: tb/sim_adc_result_bank.sv
module sim_adc_result_bank;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        conv_we;
  logic [2:0]  conv_ch;
  logic [9:0]  conv_res;
  logic        cpu_req, cpu_we, cpu_word;
  logic [3:0]  cpu_addr;
  logic [15:0] rd_data;
  logic        rd_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [9:0]  mdl_res [8];
  logic [7:0]  mdl_tmp;
  logic [15:0] exp_data;
  logic        exp_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_result_bank u0 (
    .clk(clk), .rst_n(rst_n), .conv_we(conv_we), .conv_ch(conv_ch),
    .conv_res(conv_res), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_word(cpu_word), .cpu_addr(cpu_addr), .rd_data(rd_data),
    .rd_valid(rd_valid)
  );

  function automatic logic [15:0] f_live(input logic [2:0] ch);
    return {mdl_res[ch], 6'b000000};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // One bus cycle: drive at a falling edge, model, then check at the next falling edge.
  task automatic cyc(input string tag, input logic cw, input logic [2:0] cc,
                     input logic [9:0] cr, input logic rq, input logic we,
                     input logic wd, input logic [3:0] ad);
    logic [15:0] lv;
    conv_we = cw; conv_ch = cc; conv_res = cr;
    cpu_req = rq; cpu_we = we; cpu_word = wd; cpu_addr = ad;
    lv = f_live(ad[3:1]);
    exp_valid = rq && !we;
    if (rq && !we) begin
      if (wd) begin
        exp_data = lv; mdl_tmp = lv[7:0];
      end else if (ad[0]) begin
        exp_data = {8'h00, mdl_tmp};
      end else begin
        exp_data = {8'h00, lv[15:8]}; mdl_tmp = lv[7:0];
      end
    end
    if (cw) mdl_res[cc] = cr;
    @(negedge clk);
    chk({tag, " valid"}, {15'd0, rd_valid}, {15'd0, exp_valid});
    chk({tag, " data"}, rd_data, exp_data);
  endtask

  task automatic idle();
    cyc("R11 idle", 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0;
    conv_we = 0; conv_ch = 0; conv_res = 0;
    cpu_req = 0; cpu_we = 0; cpu_word = 0; cpu_addr = 0;
    for (int i = 0; i < 8; i++) mdl_res[i] = '0;
    mdl_tmp = 8'h00; exp_data = 16'h0000; exp_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 reset valid", {15'd0, rd_valid}, 16'd0);
    chk("R7 reset data", rd_data, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7: holding byte and all registers clear after reset
    cyc("R7 lo before hi", 0, 0, 0, 1, 0, 0, 4'd5);
    for (int c = 0; c < 8; c++) cyc("R7 word zero", 0, 0, 0, 1, 0, 1, 4'(2*c));

    // R1 and R2: distinct values per channel, word readback
    for (int c = 0; c < 8; c++) cyc("R1 conv", 1, 3'(c), 10'(10'h2A5 ^ (c * 77)), 0, 0, 0, 0);
    for (int c = 0; c < 8; c++) cyc("R1 R2 word", 0, 0, 0, 1, 0, 1, 4'(2*c + 1));

    // R3 then R4 and R5: upper byte then lower byte
    cyc("R3 hi", 0, 0, 0, 1, 0, 0, 4'd6);
    cyc("R4 R5 lo", 0, 0, 0, 1, 0, 0, 4'd7);
    // R5: lower byte read does not reload; conversion in between does not affect it
    cyc("R5 conv", 1, 3'd3, 10'h3FF, 0, 0, 0, 0);
    cyc("R5 lo again", 0, 0, 0, 1, 0, 0, 4'd7);

    // R10: capture from ch2 then ch5; lower read of ch2 address returns ch5 capture
    cyc("R10 hi ch2", 0, 0, 0, 1, 0, 0, 4'd4);
    cyc("R10 hi ch5", 0, 0, 0, 1, 0, 0, 4'd10);
    cyc("R10 lo ch2", 0, 0, 0, 1, 0, 0, 4'd5);

    // R9: collision of conversion and read on one register
    cyc("R9 hi collide", 1, 3'd6, 10'h001, 1, 0, 0, 4'd12);
    cyc("R9 lo old", 0, 0, 0, 1, 0, 0, 4'd13);
    cyc("R9 word new", 0, 0, 0, 1, 0, 1, 4'd12);
    cyc("R6 R9 word collide", 1, 3'd6, 10'h3C3, 1, 0, 1, 4'd12);
    cyc("R6 lo after word", 0, 0, 0, 1, 0, 0, 4'd1);

    // R8: writes produce nothing and leave the holding byte alone
    cyc("R8 write hi", 0, 0, 0, 1, 1, 0, 4'd0);
    cyc("R8 write word", 0, 0, 0, 1, 1, 1, 4'd2);
    cyc("R8 lo unchanged", 0, 0, 0, 1, 0, 0, 4'd3);
    cyc("R8 word unchanged", 0, 0, 0, 1, 0, 1, 4'd0);
    idle();

    // Random traffic covering all requirements
    for (int k = 0; k < 4000; k++) begin
      cyc("R1 R3 R4 R5 R6 R9 R10 R11 random",
          ($urandom % 2) == 0, 3'($urandom), 10'($urandom),
          ($urandom % 5) < 3, ($urandom % 5) == 0, ($urandom % 4) == 0, 4'($urandom));
    end
    for (int c = 0; c < 8; c++) cyc("R1 final word", 0, 0, 0, 1, 0, 1, 4'(2*c));
    idle();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule